// File: doc/BRIEF.md
# Two-Channel PCM Transmit Framer with Control Echo

This block turns two companded 8-bit voice codes, each channel's power-enable bit and each channel's three control-latch values into one 28-bit serial frame. The frame goes out one bit per bit-clock cycle on a line modelled as open drain. A frame begins on the rising edge of the transmit frame sync. Each channel gets a 16-position slot. The slot holds the channel's code, most significant bit first, and then an echo group. The echo group returns the channel's power-enable bit and its three latch values, so the controller that wrote them can read them back. Four positions between the two channel slots are left undriven. Any positions after the 28th are also left undriven until the next sync edge.

A channel whose enable bit is 0 sends the all-ones idle code in its code positions, and its echo group still carries real values. When the global power input is low, the line is released for as long as it stays low, and no new frame can begin. All frame content is copied into a holding register on the cycle the frame begins, so later input changes cannot alter that frame.

The control is a three-state machine:
- OFF is entered from any state whenever power is sampled low, and on reset.
- IDLE is entered from OFF when power is sampled high with no sync edge, and from SEND after the 28th bit.
- SEND is entered from any state on a sync rising edge while powered. A sync rising edge during SEND is a resync and restarts at position 1. Otherwise SEND advances one position per clock.

Top module: `pcm_echo_tx`

## Requirements
- R1: After reset, `tx_en` is 0 and `tx_dat` is 1.
- R2: A frame starts when `fsync` is sampled high at a clock edge after being sampled low at the previous edge, with `pwr_up` high. Position 1 (channel 1 code bit 7) appears on the outputs right after that edge. Each later edge advances one position, up to position 28.
- R3: Positions 1 to 8 carry channel 1's code, bit 7 first (`pcm_code[7:0]`). Position 9 carries channel 1's enable bit (`ch_on[0]`). Positions 10, 11 and 12 carry `latch_val[2]`, `latch_val[1]` and `latch_val[0]`.
- R4: Positions 13 to 16 are not driven: `tx_en`=0 and `tx_dat`=1.
- R5: Positions 17 to 24 carry channel 2's code, bit 7 first (`pcm_code[15:8]`). Position 25 carries `ch_on[1]`. Positions 26, 27 and 28 carry `latch_val[5]`, `latch_val[4]` and `latch_val[3]`.
- R6: A channel whose enable bit is 0 sends 11111111 in its code positions. In this companding law 11111111 is +0, 01111111 is -0, 10000000 is positive full scale and 00000000 is negative full scale. That channel's echo positions still report a power bit of 0 and its latch values.
- R7: When `pwr_up` is sampled low, `tx_en` is 0 from the next cycle for as long as it stays low. No frame starts while `pwr_up` is low.
- R8: A frame's content is captured on the cycle it begins. Changes to `pcm_code`, `ch_on` or `latch_val` after that edge do not change that frame.
- R9: After position 28, the line stays released until the next frame start.
- R10: Only a rising edge of `fsync` starts a frame, so holding `fsync` high gives one frame. A rising edge in the middle of a frame restarts it at position 1 with newly captured content.
- R11: Whenever `tx_en` is 0, `tx_dat` is 1. The line is pulled low only when `tx_en`=1 and `tx_dat`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; outputs change after its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_up | input | 1 | Global power; 0 releases the line |
| fsync | input | 1 | Transmit frame sync; rising edge starts a frame |
| ch_on | input | NCH (2) | Per-channel enable; bit 0 is channel 1 |
| pcm_code | input | NCH*CODE_W (16) | Companded codes; [7:0] is channel 1 |
| latch_val | input | NCH*LAT_W (6) | Control latches echoed back; [2:0] is channel 1 |
| tx_en | output | 1 | Line is driven in this bit period |
| tx_dat | output | 1 | Bit value; 1 when released |

## Verification
The checker tracks the frame position independently of the design. On every cycle it checks the following: the first bit is driven after a start, the gap is released, the line is idle outside a frame, power-down releases the line, a released line reads 1, the power-echo bits match the enable bits captured at the start, and a disabled channel's code positions read 1. The exact code and latch bit values, isolation from input changes in mid-frame, behaviour when the sync is held high, and resync need concrete stimulus. The bench's reference model compares those bit by bit across its scenarios.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    // Control states of the transmit framer
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_SEND = 2'd2
    } tx_state_t;

    // One bit period on the line
    typedef struct packed {
        logic drive;
        logic value;
    } tx_slot_t;

endpackage

// File: rtl/pcm_tx_sync_edge.sv
module pcm_tx_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    output logic start
);
    logic sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= fsync;
    end

    // Rising edge only: a held-high sync gives a single start
    assign start = fsync & ~sync_q;

endmodule

// File: rtl/pcm_tx_frame_pack.sv
module pcm_tx_frame_pack #(
    parameter int NCH    = 2,
    parameter int CODE_W = 8,
    parameter int LAT_W  = 3,
    parameter int GAP_W  = 4,
    localparam int SLOT  = CODE_W + 1 + LAT_W + GAP_W,
    localparam int FW    = NCH * SLOT - GAP_W
) (
    input  logic [NCH-1:0]        ch_on,
    input  logic [NCH*CODE_W-1:0] pcm_code,
    input  logic [NCH*LAT_W-1:0]  latch_val,
    output logic [FW-1:0]         frame_bits,
    output logic [FW-1:0]         frame_drv
);
    // Position p (0-based, sent first at p=0) lives at vector index FW-1-p.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int BASE = c * SLOT;

        for (genvar k = 0; k < CODE_W; k++) begin : g_code
            // Disabled channel sends the all-ones idle code
            assign frame_bits[FW-1-(BASE+k)] =
                ch_on[c] ? pcm_code[c*CODE_W + CODE_W-1-k] : 1'b1;
            assign frame_drv[FW-1-(BASE+k)] = 1'b1;
        end

        assign frame_bits[FW-1-(BASE+CODE_W)] = ch_on[c];
        assign frame_drv[FW-1-(BASE+CODE_W)]  = 1'b1;

        for (genvar k = 0; k < LAT_W; k++) begin : g_latch
            assign frame_bits[FW-1-(BASE+CODE_W+1+k)] = latch_val[c*LAT_W + LAT_W-1-k];
            assign frame_drv[FW-1-(BASE+CODE_W+1+k)]  = 1'b1;
        end

        if (c < NCH-1) begin : g_gap
            for (genvar k = 0; k < GAP_W; k++) begin : g_gbit
                assign frame_bits[FW-1-(BASE+CODE_W+1+LAT_W+k)] = 1'b1;
                assign frame_drv[FW-1-(BASE+CODE_W+1+LAT_W+k)]  = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pcm_tx_fsm.sv
module pcm_tx_fsm
    import pcm_tx_pkg::*;
#(
    parameter int FW = 28,
    localparam int CW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_up,
    input  logic          start,
    input  logic [FW-1:0] frame_bits,
    input  logic [FW-1:0] frame_drv,
    output logic          tx_en,
    output logic          tx_dat
);
    tx_state_t     state, nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] sel;
    logic          last;
    logic [FW-1:0] hold_bits;
    logic [FW-1:0] hold_drv;
    tx_slot_t      slot_d, slot_q;

    assign last = (cnt == CW'(FW));
    assign sel  = CW'(FW - 1) - cnt;

    // Next-state logic
    always_comb begin
        nxt = state;
        if (!pwr_up) begin
            nxt = ST_OFF;
        end else if (start) begin
            nxt = ST_SEND;
        end else begin
            unique case (state)
                ST_OFF:  nxt = ST_IDLE;
                ST_IDLE: nxt = ST_IDLE;
                ST_SEND: nxt = last ? ST_IDLE : ST_SEND;
                default: nxt = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Frame holding register and position counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            hold_bits <= '1;
            hold_drv  <= '0;
        end else if (nxt == ST_SEND) begin
            if (start) begin
                hold_bits <= frame_bits;
                hold_drv  <= frame_drv;
                cnt       <= CW'(1);
            end else begin
                cnt <= cnt + CW'(1);
            end
        end else begin
            cnt <= '0;
        end
    end

    // Bit selection for the next period
    always_comb begin
        slot_d = '{drive: 1'b0, value: 1'b1};
        if (nxt == ST_SEND) begin
            if (start) begin
                slot_d.drive = frame_drv[FW-1];
                slot_d.value = frame_bits[FW-1] | ~frame_drv[FW-1];
            end else begin
                slot_d.drive = hold_drv[sel];
                slot_d.value = hold_bits[sel] | ~hold_drv[sel];
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '{drive: 1'b0, value: 1'b1};
        else        slot_q <= slot_d;
    end

    assign tx_en  = slot_q.drive;
    assign tx_dat = slot_q.value;

endmodule

// File: rtl/pcm_echo_tx.sv
module pcm_echo_tx #(
    parameter int NCH    = 2,
    parameter int CODE_W = 8,
    parameter int LAT_W  = 3,
    parameter int GAP_W  = 4,
    localparam int SLOT  = CODE_W + 1 + LAT_W + GAP_W,
    localparam int FW    = NCH * SLOT - GAP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_up,
    input  logic                  fsync,
    input  logic [NCH-1:0]        ch_on,
    input  logic [NCH*CODE_W-1:0] pcm_code,
    input  logic [NCH*LAT_W-1:0]  latch_val,
    output logic                  tx_en,
    output logic                  tx_dat
);
    logic          start;
    logic [FW-1:0] frame_bits;
    logic [FW-1:0] frame_drv;

    pcm_tx_sync_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .fsync (fsync),
        .start (start)
    );

    pcm_tx_frame_pack #(
        .NCH    (NCH),
        .CODE_W (CODE_W),
        .LAT_W  (LAT_W),
        .GAP_W  (GAP_W)
    ) u_pack (
        .ch_on      (ch_on),
        .pcm_code   (pcm_code),
        .latch_val  (latch_val),
        .frame_bits (frame_bits),
        .frame_drv  (frame_drv)
    );

    pcm_tx_fsm #(
        .FW (FW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_up     (pwr_up),
        .start      (start),
        .frame_bits (frame_bits),
        .frame_drv  (frame_drv),
        .tx_en      (tx_en),
        .tx_dat     (tx_dat)
    );

endmodule

// File: rtl/pcm_echo_tx_chk.sv
module pcm_echo_tx_chk #(
    parameter int NCH    = 2,
    parameter int CODE_W = 8,
    parameter int LAT_W  = 3,
    parameter int GAP_W  = 4,
    localparam int SLOT  = CODE_W + 1 + LAT_W + GAP_W,
    localparam int FW    = NCH * SLOT - GAP_W,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pwr_up,
    input logic           fsync,
    input logic [NCH-1:0] ch_on,
    input logic           tx_en,
    input logic           tx_dat
);
    logic           prev_sync;
    logic           ck_start;
    int             pos;
    logic [NCH-1:0] cap_on;
    int             off;
    logic [CHW-1:0] chn;
    logic           in_code, in_pwr, in_gap;

    assign ck_start = pwr_up & fsync & ~prev_sync;

    // Independent position tracker: pos is the frame position shown now
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sync <= 1'b0;
            pos       <= 0;
            cap_on    <= '0;
        end else begin
            prev_sync <= fsync;
            if (!pwr_up) begin
                pos <= 0;
            end else if (ck_start) begin
                pos    <= 1;
                cap_on <= ch_on;
            end else if (pos != 0 && pos < FW) begin
                pos <= pos + 1;
            end else begin
                pos <= 0;
            end
        end
    end

    always_comb begin
        off     = (pos == 0) ? 0 : (pos - 1) % SLOT;
        chn     = (pos == 0) ? '0 : CHW'((pos - 1) / SLOT);
        in_code = (pos != 0) && (off < CODE_W);
        in_pwr  = (pos != 0) && (off == CODE_W);
        in_gap  = (pos != 0) && (off > CODE_W + LAT_W);
    end

    assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ck_start |=> tx_en);

    assert_pwr_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pwr && chn == '0) |-> (tx_en && tx_dat == cap_on[chn]));

    assert_gap_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_gap |-> (!tx_en && tx_dat));

    assert_pwr_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pwr && chn != '0) |-> (tx_en && tx_dat == cap_on[chn]));

    assert_idle_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_code && !cap_on[chn]) |-> (tx_en && tx_dat));

    assert_power_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> !tx_en);

    assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == 0) |-> !tx_en);

    assert_released_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> tx_dat);

endmodule

bind pcm_echo_tx pcm_echo_tx_chk #(
    .NCH    (NCH),
    .CODE_W (CODE_W),
    .LAT_W  (LAT_W),
    .GAP_W  (GAP_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_up (pwr_up),
    .fsync  (fsync),
    .ch_on  (ch_on),
    .tx_en  (tx_en),
    .tx_dat (tx_dat)
);

// File: tb/sim_pcm_echo_tx.sv
`timescale 1ns/1ps
module sim_pcm_echo_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_up = 1'b0;
    logic        fsync = 1'b0;
    logic [1:0]  ch_on = 2'b00;
    logic [15:0] pcm_code = 16'h0000;
    logic [5:0]  latch_val = 6'b000000;
    logic        tx_en, tx_dat;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string focus = "";

    always #4 clk = ~clk;

    pcm_echo_tx u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_up    (pwr_up),
        .fsync     (fsync),
        .ch_on     (ch_on),
        .pcm_code  (pcm_code),
        .latch_val (latch_val),
        .tx_en     (tx_en),
        .tx_dat    (tx_dat)
    );

    // Reference model: fb[p] is 0/1 for a driven bit, 2 for a released slot
    int fb [1:28];
    int mpos = 0;
    bit mprev = 0;
    bit mon [0:1];

    task automatic build_frame();
        for (int p = 1; p <= 28; p++) fb[p] = 2;
        mon[0] = ch_on[0];
        mon[1] = ch_on[1];
        for (int p = 1; p <= 8; p++)   fb[p] = ch_on[0] ? int'(pcm_code[8-p]) : 1;
        fb[9] = int'(ch_on[0]);
        for (int p = 10; p <= 12; p++) fb[p] = int'(latch_val[12-p]);
        for (int p = 17; p <= 24; p++) fb[p] = ch_on[1] ? int'(pcm_code[8+24-p]) : 1;
        fb[25] = int'(ch_on[1]);
        for (int p = 26; p <= 28; p++) fb[p] = int'(latch_val[3+28-p]);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mpos  = 0;
            mprev = 0;
        end else begin
            if (!pwr_up) mpos = 0;
            else if (fsync && !mprev) begin
                build_frame();
                mpos = 1;
            end else if (mpos > 0 && mpos < 28) mpos = mpos + 1;
            else mpos = 0;
            mprev = fsync;
        end
    end

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: {en,dat} actual %b expected %b at %0t", tag, focus, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic  e_en, e_dat;
            string tag;
            e_en  = (mpos > 0) && (fb[mpos] != 2);
            e_dat = e_en ? fb[mpos][0] : 1'b1;
            if (mpos == 0)                                tag = pwr_up ? "R9" : "R7";
            else if (mpos <= 8 && !mon[0])                tag = "R6";
            else if (mpos >= 17 && mpos <= 24 && !mon[1]) tag = "R6";
            else if (mpos <= 12)                          tag = "R3";
            else if (mpos <= 16)                          tag = "R4";
            else                                          tag = "R5";
            check(tag, {tx_en, tx_dat}, {e_en, e_dat});
            if (!tx_en) check("R11", {1'b0, tx_dat}, 2'b01);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
    endtask

    initial begin
        run(3);
        // R1: reset state
        check("R1", {tx_en, tx_dat}, 2'b01);
        rst_n = 1'b1;
        run(1);
        check("R1", {tx_en, tx_dat}, 2'b01);

        // Basic frame, both channels on
        pwr_up    = 1'b1;
        ch_on     = 2'b11;
        pcm_code  = {8'h3C, 8'hA5};
        latch_val = {3'b010, 3'b101};
        run(2);
        focus = "basic";
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        // R2: channel 1 MSB right after the start edge
        check("R2", {tx_en, tx_dat}, {1'b1, 1'b1});
        run(31);

        // Full-scale and -0 codes, inverted latches
        focus = "codes";
        pcm_code  = {8'h80, 8'h7F};
        latch_val = {3'b111, 3'b000};
        pulse(); run(31);
        pcm_code  = {8'h00, 8'hFF};
        latch_val = {3'b001, 3'b110};
        pulse(); run(31);

        // R6: one channel disabled, then the other
        focus = "R6 ch1 off";
        pcm_code = {8'h12, 8'h34};
        ch_on = 2'b10;
        pulse(); run(31);
        focus = "R6 ch2 off";
        ch_on = 2'b01;
        pulse(); run(31);
        ch_on = 2'b11;

        // R8: inputs change right after the frame start
        focus = "R8 capture";
        pcm_code  = {8'hC3, 8'h5A};
        latch_val = 6'b100011;
        pulse();
        run(2);
        pcm_code  = 16'h0000;
        latch_val = 6'b011100;
        ch_on     = 2'b00;
        run(30);
        ch_on = 2'b11;

        // R10: held-high sync yields a single frame
        focus = "R10 held";
        pcm_code = {8'h96, 8'h69};
        fsync = 1'b1;
        run(45);
        fsync = 1'b0;
        run(3);
        // R10: resync in the middle of a frame
        focus = "R10 resync";
        pulse(); run(10);
        pcm_code = {8'hE1, 8'h1E};
        pulse(); run(33);

        // R7: power-down mid-frame, and a sync while powered down
        focus = "R7 power";
        pulse(); run(5);
        pwr_up = 1'b0;
        run(5);
        pulse(); run(30);
        pwr_up = 1'b1;
        run(3);
        pulse(); run(32);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not complete, actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule